// File: doc/BRIEF.md
# Double-Buffered Converter Input Register

This block is the digital front end of a 10-bit digital-to-analog converter. It keeps two storage stages. The first stage is an input latch that a host loads over a bus. The host can load it as one full 10-bit word, or build it from two 8-bit bus writes. The second stage is the converter register, and its contents drive the ladder switches. A separate active-low transfer strobe moves the assembled word into the converter register. Several converters can share one strobe, so all of their outputs change on the same clock edge.

The input latch has two parts: an upper part of 8 bits and a lower part of 2 bits. When the word-mode select is high, a write loads both parts. When it is low, a write loads only the lower part, from the top two lines of the 8-bit bus. A transfer is allowed only while word-mode select is low.

All controls act on level and are sampled on the rising clock edge. Two operating styles follow from holding controls asserted. Holding write and transfer asserted together gives flow-through behaviour. Holding only transfer asserted gives single-buffered behaviour.

Top module: `dbuf_dac_input`

## Requirements
- R1: While reset is asserted, the converter code and both parts of the input latch are zero. A transfer right after reset therefore yields code 0.
- R2: While chip select `cs_n` is high (1), a write changes neither part of the input latch.
- R3: A write on an edge with `cs_n`=0, `wr_n`=0 and `word_mode`=1 loads the whole 10-bit input latch from `din[9:0]`. Bit 9 is the MSB and bit 0 is the LSB.
- R4: A write with `word_mode`=0 loads only the lower two latch bits, from `din[9:8]` (the top two lines of an 8-bit bus placed on `din[9:2]`). The upper eight latch bits are kept.
- R5: On an edge with `xfer_n`=0 and `word_mode`=0, the converter register takes the input latch value. A two-byte load followed by a transfer gives {first byte, second-byte bits 7:6}.
- R6: A transfer attempted while `word_mode`=1 leaves the converter code unchanged.
- R7: While `xfer_n`=1, the converter code holds its value.
- R8: When a write and a transfer are both active on the same edge, the converter register takes the value written on that edge (flow-through).
- R9: The transfer strobe acts whatever the level of `cs_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select, gates writes |
| wr_n | input | 1 | Active-low write |
| word_mode | input | 1 | 1: write loads all ten bits; 0: write loads low two bits and permits transfer |
| xfer_n | input | 1 | Active-low transfer strobe |
| din | input | 10 | Data lines, left justified |
| code | output | 10 | Converter register contents driving the ladder |

## Verification
The input latch cannot be seen at the ports. A wrong latch value therefore shows up only on the first allowed transfer after the bad write, one edge later, as a wrong `code`. The bench follows every latch-loading sequence with a transfer. A bad gating of the converter register shows at once: `code` changes on the same edge that a blocked or idle transfer should have left alone. Flow-through cases are checked one edge after the combined write and transfer.

// File: rtl/dbuf_dac_pkg.sv
package dbuf_dac_pkg;

  typedef struct packed {
    logic hi_en;
    logic lo_en;
    logic load_en;
  } dbuf_ctl_t;

  // Source for the low latch bits: full-word write takes the word LSBs,
  // byte write takes the top lines of the byte lane.
  function automatic logic [1:0] low_src2(input logic [9:0] d, input logic full);
    return full ? d[1:0] : d[9:8];
  endfunction

  function automatic logic [9:0] join_word(input logic [7:0] hi, input logic [1:0] lo);
    return {hi, lo};
  endfunction

endpackage

// File: rtl/dbuf_dac_ctrl.sv
module dbuf_dac_ctrl
  import dbuf_dac_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       wr_n,
  input  logic       word_mode,
  input  logic       xfer_n,
  output dbuf_ctl_t  ctl
);
  logic write_req;

  always_comb begin
    write_req   = !cs_n && !wr_n;
    ctl.hi_en   = write_req && word_mode;
    ctl.lo_en   = write_req;
    ctl.load_en = !xfer_n && !word_mode;
  end

  // R6: no transfer is ever enabled while word mode is set
  a_r6_no_load_in_word_mode: assert property (@(posedge clk) disable iff (!rst_n)
    word_mode |-> !ctl.load_en);
  // R2: chip select high suppresses every latch enable
  a_r2_cs_gates_write: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !(ctl.hi_en || ctl.lo_en));
endmodule

// File: rtl/dbuf_dac_in_latch.sv
module dbuf_dac_in_latch
  import dbuf_dac_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int BUS_W  = 8,
  localparam int LO_W  = DATA_W - BUS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hi_en,
  input  logic              lo_en,
  input  logic              word_mode,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] word_q,
  output logic [DATA_W-1:0] word_nxt
);
  logic [BUS_W-1:0] hi_q, hi_nxt;
  logic [LO_W-1:0]  lo_q, lo_nxt, lo_src;

  always_comb lo_src = low_src2(din, word_mode);

  always_comb hi_nxt = hi_en ? din[DATA_W-1 -: BUS_W] : hi_q;

  for (genvar b = 0; b < LO_W; b++) begin : g_lo
    always_comb lo_nxt[b] = lo_en ? lo_src[b] : lo_q[b];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lo_q[b] <= 1'b0;
      else        lo_q[b] <= lo_nxt[b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_q <= '0;
    else        hi_q <= hi_nxt;
  end

  assign word_q   = join_word(hi_q, lo_q);
  assign word_nxt = join_word(hi_nxt, lo_nxt);

  // R4: a byte-only write keeps the upper part
  a_r4_hi_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_en |=> $stable(hi_q));
  // R3: a full-word write captures the upper data lines
  a_r3_hi_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    hi_en |=> hi_q == $past(din[DATA_W-1 -: BUS_W]));
endmodule

// File: rtl/dbuf_dac_out_reg.sv
module dbuf_dac_out_reg #(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [DATA_W-1:0] src,
  output logic [DATA_W-1:0] code
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code <= '0;
    else if (load_en) code <= src;
  end

  // R5: an enabled transfer copies the latch source
  a_r5_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> code == $past(src));
  // R7: no enable, no change
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(code));
endmodule

// File: rtl/dbuf_dac_input.sv
module dbuf_dac_input
  import dbuf_dac_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int BUS_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              word_mode,
  input  logic              xfer_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] code
);
  dbuf_ctl_t         ctl;
  logic [DATA_W-1:0] word_q, word_nxt;

  dbuf_dac_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n),
    .word_mode(word_mode), .xfer_n(xfer_n), .ctl(ctl)
  );

  dbuf_dac_in_latch #(.DATA_W(DATA_W), .BUS_W(BUS_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .hi_en(ctl.hi_en), .lo_en(ctl.lo_en),
    .word_mode(word_mode), .din(din), .word_q(word_q), .word_nxt(word_nxt)
  );

  // Flow-through: the converter register sees the value being written.
  dbuf_dac_out_reg #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load_en(ctl.load_en), .src(word_nxt), .code(code)
  );

  // R2: chip select high leaves the input latch untouched
  a_r2_latch_stable: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> $stable(word_q));
  // R6: transfer under word mode leaves the code unchanged
  a_r6_code_stable: assert property (@(posedge clk) disable iff (!rst_n)
    word_mode |=> $stable(code));
  // R9: transfer works with chip select high
  a_r9_xfer_no_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && !xfer_n && !word_mode) |=> code == $past(word_q));
endmodule

// File: tb/dbuf_dac_input_tb.sv
module dbuf_dac_input_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       cs_n = 1, wr_n = 1, word_mode = 0, xfer_n = 1;
  logic [9:0] din = '0;
  logic [9:0] code;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dbuf_dac_input u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n),
    .word_mode(word_mode), .xfer_n(xfer_n), .din(din), .code(code)
  );

  // {cs_n, wr_n, word_mode, xfer_n, din, expected code after the edge}
  localparam int NV = 13;
  localparam logic [23:0] VEC [NV] = '{
    {4'b0011, 10'h2A5, 10'h000},  // full write, no transfer
    {4'b0100, 10'h000, 10'h2A5},  // transfer full word
    {4'b0011, 10'h30C, 10'h2A5},  // first byte 0xC3, no transfer
    {4'b0001, 10'h200, 10'h2A5},  // second byte bits 7:6 = 10
    {4'b0100, 10'h000, 10'h30E},  // transfer assembled word
    {4'b1011, 10'h3FF, 10'h30E},  // write with cs high
    {4'b0100, 10'h000, 10'h30E},  // transfer shows latch unchanged
    {4'b0011, 10'h155, 10'h30E},  // full write
    {4'b0110, 10'h000, 10'h30E},  // transfer blocked in word mode
    {4'b1100, 10'h000, 10'h155},  // transfer with cs high
    {4'b0000, 10'h300, 10'h157},  // flow-through byte write
    {4'b0000, 10'h000, 10'h154},  // flow-through again
    {4'b1000, 10'h300, 10'h154}   // flow with cs high: write ignored
  };

  function automatic string tag_of(input int i);
    case (i)
      0, 7:    return "R3";
      1:       return "R5";
      2:       return "R7";
      3, 4:    return "R4";
      5, 6, 12: return "R2";
      8:       return "R6";
      9:       return "R9";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string tag, input logic [9:0] exp);
    checks++;
    if (code !== exp) begin
      failures++;
      $display("FAIL %s code=%h expected=%h", tag, code, exp);
    end
  endtask

  task automatic step(input logic [3:0] c, input logic [9:0] d);
    {cs_n, wr_n, word_mode, xfer_n} = c;
    din = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 10'h000);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][23:20], VEC[i][19:10]);
      check(tag_of(i), VEC[i][9:0]);
    end
    // R1: reset mid-run clears code and latch
    rst_n = 0;
    @(negedge clk);
    check("R1", 10'h000);
    rst_n = 1;
    @(negedge clk);
    step(4'b0100, 10'h3FF);
    check("R1", 10'h000);
    // R7: idle edges hold after a fresh load
    step(4'b0011, 10'h3C0);
    step(4'b0001, 10'h100);
    step(4'b0100, 10'h000);
    check("R5", 10'h3C1);
    step(4'b0111, 10'h000);
    check("R7", 10'h3C1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule